// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Parity Select

This block takes 32-bit avionics data words from a host that has only a 16-bit data path. The host presents the lower half of a word and pulses one strobe, then presents the upper half and pulses a second strobe. The assembled word goes into a 32-entry queue. While the transmit enable is high, the block takes words from the queue one at a time. It sends each one as a bipolar return-to-zero stream: there is one drive output for a One and another for a Zero, and both are low during the Null half of every bit and in the gap between words.

The last bit of each word can be replaced by a parity bit that makes the total count of ones odd or even. It can also be sent unchanged as data. A rate select chooses between a fast and a slow bit period. Three status outputs tell the host how far it can go: a ready flag, a half-full flag and a full flag.

Top module: `a429_tx_engine`

## Requirements
- R1: A pulse on `strobe_lo` captures `bus_data` as word bits [15:0] (serial bits 1 to 16). A later pulse on `strobe_hi` queues the word {`bus_data`, captured half}, so word bit n-1 is serial bit n. A `strobe_hi` with no `strobe_lo` since the previous `strobe_hi` queues nothing.
- R2: The queue holds 32 words. A second strobe while `fifo_full` is high is dropped. Neither the word being sent nor the queued words change.
- R3: `fifo_half` is high while 16 or more words are queued. `fifo_full` is high while 32 are queued. Both are registered and follow the occupancy from the cycle after the change.
- R4: `tx_ready` is 1 after reset and goes to 0 in the cycle after any accepted load. It returns to 1 only when no word is being serialized and the queue is empty.
- R5: A word is taken from the queue only while `tx_en` is high. Its first drive phase appears two clocks after the edge on which it was taken.
- R6: Send order: word bits 7 down to 0 (the label, most significant bit first), then word bits 8 up to 31.
- R7: For a One, `line_one` is high for the first half-bit period. For a Zero, `line_zero` is high for that time. Both are low for the second half, and the two are never high together.
- R8: With `par_en`=1 and `par_even`=0, the last serial bit is chosen so that all 32 bits hold an odd number of ones.
- R9: With `par_en`=1 and `par_even`=1, the last serial bit makes the count of ones even.
- R10: With `par_en`=0, word bit 31 is sent unchanged.
- R11: Between the Null half of one word's last bit and the next word's first drive, both lines stay low for at least 8 half-bit periods plus 2 clocks.
- R12: A half-bit lasts `HALF_FAST` clocks, or `HALF_FAST*SLOW_MULT` clocks when `slow_rate`=1. The rate and parity controls are sampled once per word, when the word is taken for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 16 | Host data half-word |
| strobe_lo | input | 1 | Captures the lower half-word |
| strobe_hi | input | 1 | Completes and queues the word |
| tx_en | input | 1 | Permits starting a word |
| par_en | input | 1 | Replace bit 32 with parity |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| slow_rate | input | 1 | Selects the long bit period |
| line_one | output | 1 | Drive enable for a One |
| line_zero | output | 1 | Drive enable for a Zero |
| tx_ready | output | 1 | Queue empty and line idle |
| fifo_half | output | 1 | Queue at least half full |
| fifo_full | output | 1 | Queue full |

## Verification
A host load and the serializer's removal of a word from the queue can fall on the same clock edge. This matters most when the queue is full, and when the queue holds one word while the ready flag is settling. The bench provokes this by keeping loads going while transmission runs on a full queue, so each pop races a second strobe. The reference model decides acceptance from the occupancy before the edge and then applies the pop and the push. On every clock it compares the occupancy flags, the ready flag and both line outputs against the model.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOAD,
    TX_DATA,
    TX_GAP
  } tx_state_e;

  // Reorder a word so that index 31 is the first serial bit:
  // label bits 7..0, then bits 8..31.
  function automatic logic [31:0] serial_order(input logic [31:0] w);
    logic [31:0] s;
    for (int b = 0; b < 32; b++) begin
      if (b < 8) s[31-b] = w[7-b];
      else       s[31-b] = w[b];
    end
    return s;
  endfunction

endpackage

// File: rtl/a429_tx_loader.sv
module a429_tx_loader #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] bus_data,
  input  logic          strobe_lo,
  input  logic          strobe_hi,
  input  logic          full,
  output logic          wr_en,
  output logic [2*HW-1:0] wr_data
);
  logic          armed;
  logic [HW-1:0] low_half;

  assign wr_en   = strobe_hi && armed && !full;
  assign wr_data = {bus_data, low_half};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      low_half <= '0;
    end else if (strobe_lo) begin
      armed    <= 1'b1;
      low_half <= bus_data;
    end else if (strobe_hi) begin
      armed    <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          half,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (wr_en) cnt_n = cnt_n + 1'b1;
    if (rd_en) cnt_n = cnt_n - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      half  <= 1'b0;
      full  <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      cnt   <= cnt_n;
      empty <= (cnt_n == 0);
      half  <= (cnt_n >= (AW+1)'(DEPTH/2));
      full  <= (cnt_n == (AW+1)'(DEPTH));
    end
  end
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int HALF_FAST = 4,
  parameter int SLOW_MULT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_en,
  input  logic        fifo_empty,
  input  logic [31:0] rd_data,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        slow_rate,
  output logic        rd_en,
  output logic        busy,
  output logic        line_one,
  output logic        line_zero
);
  localparam int HALF_SLOW = HALF_FAST * SLOW_MULT;
  localparam int HCW       = $clog2(HALF_SLOW + 1);

  tx_state_e   st;
  logic [31:0] seq, load_word;
  logic [HCW-1:0] hc, cur_half, sel_half;
  logic [4:0]  bi;
  logic        ph;
  logic [2:0]  gcnt;

  assign rd_en = (st == TX_IDLE) && tx_en && !fifo_empty;
  assign busy  = (st == TX_LOAD) || (st == TX_DATA);

  always_comb begin
    load_word = rd_data;
    if (par_en) load_word[31] = par_even ? (^rd_data[30:0]) : ~(^rd_data[30:0]);
    sel_half = slow_rate ? HCW'(HALF_SLOW) : HCW'(HALF_FAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      seq       <= '0;
      hc        <= '0;
      cur_half  <= HCW'(HALF_FAST);
      bi        <= '0;
      ph        <= 1'b0;
      gcnt      <= '0;
      line_one  <= 1'b0;
      line_zero <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          line_one  <= 1'b0;
          line_zero <= 1'b0;
          if (rd_en) st <= TX_LOAD;
        end
        TX_LOAD: begin
          seq       <= serial_order(load_word);
          line_one  <= load_word[7];
          line_zero <= ~load_word[7];
          cur_half  <= sel_half;
          hc        <= sel_half - HCW'(1);
          bi        <= '0;
          ph        <= 1'b0;
          st        <= TX_DATA;
        end
        TX_DATA: begin
          if (hc != '0) begin
            hc <= hc - HCW'(1);
          end else begin
            hc <= cur_half - HCW'(1);
            if (!ph) begin
              line_one  <= 1'b0;
              line_zero <= 1'b0;
              ph        <= 1'b1;
            end else if (bi == 5'd31) begin
              gcnt <= '0;
              st   <= TX_GAP;
            end else begin
              bi        <= bi + 5'd1;
              ph        <= 1'b0;
              seq       <= seq << 1;
              line_one  <= seq[30];
              line_zero <= ~seq[30];
            end
          end
        end
        default: begin
          line_one  <= 1'b0;
          line_zero <= 1'b0;
          if (hc != '0) begin
            hc <= hc - HCW'(1);
          end else begin
            hc <= cur_half - HCW'(1);
            if (gcnt == 3'd7) st <= TX_IDLE;
            else              gcnt <= gcnt + 3'd1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_engine.sv
module a429_tx_engine #(
  parameter int DEPTH     = 32,
  parameter int HALF_FAST = 4,
  parameter int SLOW_MULT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_data,
  input  logic        strobe_lo,
  input  logic        strobe_hi,
  input  logic        tx_en,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        slow_rate,
  output logic        line_one,
  output logic        line_zero,
  output logic        tx_ready,
  output logic        fifo_half,
  output logic        fifo_full
);
  localparam int HW = 16;
  localparam int DW = 2 * HW;

  logic          wr_ok, rd_en, busy, fifo_empty;
  logic [DW-1:0] wr_data, rd_data;

  a429_tx_loader #(.HW(HW)) u_ld (
    .clk(clk), .rst(rst), .bus_data(bus_data),
    .strobe_lo(strobe_lo), .strobe_hi(strobe_hi), .full(fifo_full),
    .wr_en(wr_ok), .wr_data(wr_data)
  );

  a429_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .empty(fifo_empty), .half(fifo_half), .full(fifo_full)
  );

  a429_tx_serializer #(.HALF_FAST(HALF_FAST), .SLOW_MULT(SLOW_MULT)) u_ser (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_empty(fifo_empty),
    .rd_data(rd_data), .par_en(par_en), .par_even(par_even),
    .slow_rate(slow_rate), .rd_en(rd_en), .busy(busy),
    .line_one(line_one), .line_zero(line_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)                      tx_ready <= 1'b1;
    else if (wr_ok)               tx_ready <= 1'b0;
    else if (!busy && fifo_empty) tx_ready <= 1'b1;
  end
endmodule

// File: rtl/a429_tx_checks.sv
module a429_tx_checks (
  input logic clk,
  input logic rst,
  input logic line_one,
  input logic line_zero,
  input logic tx_ready,
  input logic fifo_half,
  input logic fifo_full,
  input logic wr_ok,
  input logic rd_en,
  input logic busy
);
  a_r7_lines_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(line_one && line_zero));

  a_r3_full_has_half: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> fifo_half);

  a_r4_load_drops_ready: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> !tx_ready);

  a_r4_ready_low_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_ready);

  a_r2_full_holds_without_pop: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !rd_en) |=> fifo_full);
endmodule

bind a429_tx_engine a429_tx_checks u_chk (
  .clk(clk), .rst(rst), .line_one(line_one), .line_zero(line_zero),
  .tx_ready(tx_ready), .fifo_half(fifo_half), .fifo_full(fifo_full),
  .wr_ok(wr_ok), .rd_en(rd_en), .busy(busy)
);

// File: tb/tb_a429_tx_engine.sv
module tb_a429_tx_engine;
  localparam int DEPTH = 32;
  localparam int HF    = 2;
  localparam int SM    = 4;

  logic clk = 0, rst = 1;
  logic [15:0] bus_data = 0;
  logic strobe_lo = 0, strobe_hi = 0, tx_en = 0;
  logic par_en = 1, par_even = 0, slow_rate = 0;
  logic line_one, line_zero, tx_ready, fifo_half, fifo_full;

  always #10 clk = ~clk;

  a429_tx_engine #(.DEPTH(DEPTH), .HALF_FAST(HF), .SLOW_MULT(SM)) dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .strobe_lo(strobe_lo),
    .strobe_hi(strobe_hi), .tx_en(tx_en), .par_en(par_en), .par_even(par_even),
    .slow_rate(slow_rate), .line_one(line_one), .line_zero(line_zero),
    .tx_ready(tx_ready), .fifo_half(fifo_half), .fifo_full(fifo_full)
  );

  int total = 0, fails = 0;
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] q[$];
  bit          m_armed, m_ready;
  logic [15:0] m_low;
  int          m_st, m_t, m_h;
  logic [31:0] m_cur, m_word;

  function automatic bit ser_bit(input logic [31:0] w, input int b);
    return (b < 8) ? w[7-b] : w[b];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_armed = 0; m_ready = 1; m_low = 0;
      m_st = 0; m_t = 0; m_h = HF;
    end else begin
      int  sz;
      bit  acc, sending;
      sz      = q.size();
      acc     = strobe_hi && m_armed && (sz != DEPTH);
      sending = (m_st == 1) || (m_st == 2 && m_t < 64 * m_h);
      if (acc) m_ready = 0;
      else if (!sending && sz == 0) m_ready = 1;
      case (m_st)
        0: if (tx_en && sz > 0) begin m_cur = q.pop_front(); m_st = 1; end
        1: begin
          int ones;
          ones   = $countones(m_cur[30:0]);
          m_word = m_cur;
          if (par_en) m_word[31] = par_even ? ones[0] : ~ones[0];
          m_h  = slow_rate ? HF * SM : HF;
          m_t  = 0;
          m_st = 2;
        end
        default: begin
          m_t++;
          if (m_t == 72 * m_h) m_st = 0;
        end
      endcase
      if (acc) q.push_back({bus_data, m_low});
      if (strobe_lo) begin m_armed = 1; m_low = bus_data; end
      else if (strobe_hi) m_armed = 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit e1, e0;
      string lt;
      e1 = 0; e0 = 0;
      lt = cur_tag;
      if (m_st == 2 && m_t < 64 * m_h) begin
        int b;
        b = m_t / (2 * m_h);
        if ((m_t % (2 * m_h)) < m_h) begin
          e1 = ser_bit(m_word, b);
          e0 = ~e1;
        end
      end else if (m_st != 0) begin
        lt = "R11";
      end
      chk(line_one == e1, lt, "R6 R7 line_one", line_one, e1);
      chk(line_zero == e0, lt, "R7 line_zero", line_zero, e0);
      chk(fifo_half == (q.size() >= DEPTH/2), "R3", "fifo_half", fifo_half, q.size() >= DEPTH/2);
      chk(fifo_full == (q.size() == DEPTH), "R3", "fifo_full", fifo_full, q.size() == DEPTH);
      chk(tx_ready == m_ready, "R4", "tx_ready", tx_ready, m_ready);
    end
  end

  task automatic load(input logic [31:0] w);
    @(negedge clk); bus_data = w[15:0]; strobe_lo = 1;
    @(negedge clk); strobe_lo = 0; bus_data = w[31:16]; strobe_hi = 1;
    @(negedge clk); strobe_hi = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (m_st == 0 && q.size() == 0 && !strobe_hi) break;
    end
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] lf = 32'h1D5A_C3E7;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R4 / R3 / R7 reset state
    chk(tx_ready == 1, "R4", "ready after reset", tx_ready, 1);
    chk(fifo_half == 0 && fifo_full == 0, "R3", "flags after reset", {fifo_half, fifo_full}, 0);
    chk(line_one == 0 && line_zero == 0, "R7", "lines after reset", {line_one, line_zero}, 0);

    // R1: a second strobe without a first queues nothing
    cur_tag = "R1";
    @(negedge clk); bus_data = 16'hBEEF; strobe_hi = 1;
    @(negedge clk); strobe_hi = 0;
    repeat (2) @(negedge clk);
    chk(tx_ready == 1, "R1", "lone strobe_hi must not queue", tx_ready, 1);

    // R5: words wait while tx_en is low
    cur_tag = "R5";
    load(32'h8000_0001); load(32'h1234_56A5); load(32'h0000_00FF);
    repeat (40) @(negedge clk);
    chk(line_one == 0 && line_zero == 0, "R5", "no output while disabled", {line_one, line_zero}, 0);
    chk(tx_ready == 0, "R4", "ready low with queued words", tx_ready, 0);

    // R8: odd parity
    cur_tag = "R8";
    tx_en = 1;
    drain();
    chk(tx_ready == 1, "R4", "ready after drain", tx_ready, 1);

    // R9: even parity
    cur_tag = "R9"; par_even = 1;
    load(32'h0F0F_0F01); load(32'h7FFF_FFFE);
    drain();

    // R10: raw bit 32
    cur_tag = "R10"; par_en = 0;
    load(32'h8000_0080); load(32'h0000_0003); load(32'hFFFF_FFFF);
    drain();

    // R12: slow rate
    cur_tag = "R12"; par_en = 1; par_even = 0; slow_rate = 1;
    load(32'hA5C3_3C5A);
    drain();
    slow_rate = 0;

    // R3 / R2: fill, overflow, then load while sending on a full queue
    cur_tag = "R2"; tx_en = 0;
    for (int i = 0; i < 15; i++) begin lf = nxt(lf); load(lf); end
    @(negedge clk);
    chk(fifo_half == 0, "R3", "half low at 15", fifo_half, 0);
    lf = nxt(lf); load(lf);
    @(negedge clk);
    chk(fifo_half == 1, "R3", "half high at 16", fifo_half, 1);
    for (int i = 0; i < 18; i++) begin lf = nxt(lf); load(lf); end
    @(negedge clk);
    chk(fifo_full == 1, "R2", "full after overflow loads", fifo_full, 1);
    tx_en = 1;
    for (int i = 0; i < 6; i++) begin lf = nxt(lf); load(lf); end
    drain();
    chk(tx_ready == 1 && q.size() == 0, "R2", "all accepted words sent", tx_ready, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule